// File: doc/BRIEF.md
# Register Tag and Busy Tracker

This block keeps the rename state of a small floating-point register file for an out-of-order issue stage. Every architectural register carries a busy flag, a producer tag naming the unit (or fetch buffer) that will deliver its next value, a precision flag for that pending producer, and the last committed value. When an instruction issues, the block reads the two named registers combinationally. Each operand comes back either as a ready value or as the tag of the unit that will produce it. In the same step the block marks the written register with the tag of the unit chosen for the operation.

The block also watches the shared result bus. A busy register whose producer tag equals the broadcast tag takes the broadcast value and becomes idle. A register that has since been retagged ignores the older producer. As a result, only the most recent writer of a register ever lands in it.

Loads start a new dependency chain whatever the register's state. A register-to-register move from a busy register copies only the tag, so no execution unit is used. A write whose precision differs from the pending producer of a busy register stalls issue until that register becomes idle.

Top module: `reg_tag_tracker`

## Requirements
- R1: After reset every register is idle with value 0, so reading any register reports ready with data 0, and the stall output is low.
- R2: An issue of op class 0 (arithmetic, `issueOp` = 2'd0) marks register `issueDst` busy with producer tag `issueTag` and precision `issueDouble`. In the same cycle, the sink operand port reports register `issueDst` and the source operand port reports register `issueSrc`: ready with the value when the register is idle, or not ready with its tag when it is busy.
- R3: A busy source or sink register never stalls issue; its current tag is presented on the operand port in place of data.
- R4: A result-bus broadcast (`cdbValid` high) whose tag equals a busy register's tag writes `cdbData` into that register and clears its busy flag at the next edge. Every register holding that tag does so.
- R5: A busy register whose tag differs from the broadcast tag keeps its busy flag, tag and value.
- R6: An issue of op class 1 (load, 2'd1) marks `issueDst` busy with tag `issueTag` even when it was already busy under another tag.
- R7: An issue of op class 2 (register move, 2'd2) copies register `issueSrc` into `issueDst`. If the source is ready, the destination becomes idle with the source value. If the source is busy, the destination becomes busy with the source's tag, and both later latch the same broadcast.
- R8: For op classes 0, 1 and 2, if `issueDst` is busy and its precision flag differs from `issueDouble`, `issueStall` is high in that cycle and no register changes. The condition is judged on the state at the start of the cycle. Once the register is idle the same issue proceeds.
- R9: An issue of op class 3 (store, 2'd3) reads register `issueDst` on the sink operand port and changes no register.
- R10: When an issue writes a register in the same cycle as a broadcast matching that register's old tag, the new tag wins and the register stays busy. Any operand read of a register matched by the broadcast in that cycle returns ready with the broadcast data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issueValid | input | 1 | Issue request present |
| issueOp | input | 2 | Op class: 0 arithmetic, 1 load, 2 move, 3 store |
| issueDst | input | IDX_W | Register written (or read, for store) |
| issueSrc | input | IDX_W | Source register |
| issueTag | input | TAG_W | Tag of the unit or fetch buffer assigned |
| issueDouble | input | 1 | 1 for double precision, 0 for single |
| issueStall | output | 1 | Issue held for a precision conflict |
| sinkReady | output | 1 | Register `issueDst` value available |
| sinkTag | output | TAG_W | Producer tag of register `issueDst` |
| sinkData | output | DATA_W | Value of register `issueDst` |
| srcReady | output | 1 | Register `issueSrc` value available |
| srcTag | output | TAG_W | Producer tag of register `issueSrc` |
| srcData | output | DATA_W | Value of register `issueSrc` |
| cdbValid | input | 1 | Result broadcast present |
| cdbTag | input | TAG_W | Tag of the broadcasting unit |
| cdbData | input | DATA_W | Broadcast result |

## Verification
An issue that retags a register and a broadcast completing that register's previous producer can arrive in the same cycle. The bench provokes this by issuing an arithmetic op whose sink and source are a busy register while driving the broadcast of that register's current tag. It judges the outcome in two places. In that same cycle, both operand ports must show ready with the broadcast data. A later store read must show the register still busy under the new tag, and that register must then take only the newer producer's broadcast.

// File: rtl/rtt_pkg.sv
package rtt_pkg;

  typedef enum logic [1:0] {
    OP_ARITH = 2'd0,
    OP_LOAD  = 2'd1,
    OP_MOVE  = 2'd2,
    OP_STORE = 2'd3
  } issueOp_e;

  typedef enum logic [1:0] {
    WR_NONE    = 2'd0,
    WR_RETAG   = 2'd1,
    WR_COPYTAG = 2'd2,
    WR_COPYVAL = 2'd3
  } wrMode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic    fire;
    wrMode_e mode;
  } ctrlStrobe_t;

  // status from datapath back to control
  typedef struct packed {
    logic dstBusy;
    logic dstDouble;
    logic srcReady;
  } dpStatus_t;

endpackage

// File: rtl/rtt_readport.sv
module rtt_readport #(
  parameter int NUM_REGS = 4,
  parameter int TAG_W    = 4,
  parameter int DATA_W   = 64,
  parameter int IDX_W    = 2
) (
  input  logic [IDX_W-1:0]                 sel,
  input  logic [NUM_REGS-1:0]              busyVec,
  input  logic [NUM_REGS-1:0][TAG_W-1:0]   tagVec,
  input  logic [NUM_REGS-1:0][DATA_W-1:0]  valVec,
  input  logic                             cdbValid,
  input  logic [TAG_W-1:0]                 cdbTag,
  input  logic [DATA_W-1:0]                cdbData,
  output logic                             ready,
  output logic [TAG_W-1:0]                 tag,
  output logic [DATA_W-1:0]                data
);

  logic busySel;
  logic bypassHit;

  always_comb begin
    busySel   = busyVec[sel];
    tag       = tagVec[sel];
    bypassHit = busySel && cdbValid && (cdbTag == tagVec[sel]);
    ready     = !busySel || bypassHit;
    data      = bypassHit ? cdbData : valVec[sel];
  end

endmodule

// File: rtl/rtt_ctrl.sv
module rtt_ctrl
  import rtt_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        issueValid,
  input  logic [1:0]  issueOp,
  input  logic        issueDouble,
  input  dpStatus_t   status,
  output logic        issueStall,
  output ctrlStrobe_t strobe
);

  issueOp_e opClass;
  logic     writesReg;
  logic     precClash;

  always_comb begin
    opClass    = issueOp_e'(issueOp);
    writesReg  = (opClass != OP_STORE);
    precClash  = status.dstBusy && (status.dstDouble != issueDouble);
    issueStall = issueValid && writesReg && precClash;

    strobe.fire = issueValid && !issueStall;
    strobe.mode = WR_NONE;
    if (strobe.fire) begin
      unique case (opClass)
        OP_ARITH, OP_LOAD: strobe.mode = WR_RETAG;
        OP_MOVE:           strobe.mode = status.srcReady ? WR_COPYVAL : WR_COPYTAG;
        default:           strobe.mode = WR_NONE;
      endcase
    end
  end

  // R8: a stalled request must not reach the register state
  a_r8_stall_blocks_write: assert property (@(posedge clk) disable iff (!rst_n)
    issueStall |-> (strobe.mode == WR_NONE));

  // R9: a store never asks the datapath for a write
  a_r9_store_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (issueValid && issueOp == 2'd3) |-> (strobe.mode == WR_NONE && !issueStall));

endmodule

// File: rtl/rtt_data.sv
module rtt_data
  import rtt_pkg::*;
#(
  parameter int NUM_REGS = 4,
  parameter int TAG_W    = 4,
  parameter int DATA_W   = 64,
  parameter int IDX_W    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ctrlStrobe_t       strobe,
  input  logic [IDX_W-1:0]  issueDst,
  input  logic [IDX_W-1:0]  issueSrc,
  input  logic [TAG_W-1:0]  issueTag,
  input  logic              issueDouble,
  input  logic              cdbValid,
  input  logic [TAG_W-1:0]  cdbTag,
  input  logic [DATA_W-1:0] cdbData,
  output dpStatus_t         status,
  output logic              sinkReady,
  output logic [TAG_W-1:0]  sinkTag,
  output logic [DATA_W-1:0] sinkData,
  output logic              srcReady,
  output logic [TAG_W-1:0]  srcTag,
  output logic [DATA_W-1:0] srcData
);

  logic [NUM_REGS-1:0]             busyQ;
  logic [NUM_REGS-1:0]             dblQ;
  logic [NUM_REGS-1:0][TAG_W-1:0]  tagQ;
  logic [NUM_REGS-1:0][DATA_W-1:0] valQ;

  logic [NUM_REGS-1:0] wrHit;
  logic [NUM_REGS-1:0] cdbHit;
  logic                srcDouble;

  localparam int NUM_PORTS = 2;
  logic [IDX_W-1:0]  portSel   [NUM_PORTS];
  logic              portReady [NUM_PORTS];
  logic [TAG_W-1:0]  portTag   [NUM_PORTS];
  logic [DATA_W-1:0] portData  [NUM_PORTS];

  assign portSel[0] = issueDst;
  assign portSel[1] = issueSrc;

  // port 0 serves the sink/store register, port 1 the source register
  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    rtt_readport #(
      .NUM_REGS(NUM_REGS), .TAG_W(TAG_W), .DATA_W(DATA_W), .IDX_W(IDX_W)
    ) u_port (
      .sel      (portSel[p]),
      .busyVec  (busyQ),
      .tagVec   (tagQ),
      .valVec   (valQ),
      .cdbValid (cdbValid),
      .cdbTag   (cdbTag),
      .cdbData  (cdbData),
      .ready    (portReady[p]),
      .tag      (portTag[p]),
      .data     (portData[p])
    );
  end

  always_comb begin
    sinkReady = portReady[0];
    sinkTag   = portTag[0];
    sinkData  = portData[0];
    srcReady  = portReady[1];
    srcTag    = portTag[1];
    srcData   = portData[1];
    srcDouble = dblQ[issueSrc];

    status.dstBusy   = busyQ[issueDst];
    status.dstDouble = dblQ[issueDst];
    status.srcReady  = portReady[1];

    for (int i = 0; i < NUM_REGS; i++) begin
      wrHit[i]  = (strobe.mode != WR_NONE) && (issueDst == IDX_W'(i));
      cdbHit[i] = busyQ[i] && cdbValid && (cdbTag == tagQ[i]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busyQ <= '0;
      dblQ  <= '0;
      tagQ  <= '0;
      valQ  <= '0;
    end else begin
      for (int i = 0; i < NUM_REGS; i++) begin
        if (wrHit[i]) begin
          unique case (strobe.mode)
            WR_RETAG: begin
              busyQ[i] <= 1'b1;
              tagQ[i]  <= issueTag;
              dblQ[i]  <= issueDouble;
            end
            WR_COPYTAG: begin
              busyQ[i] <= 1'b1;
              tagQ[i]  <= srcTag;
              dblQ[i]  <= srcDouble;
            end
            WR_COPYVAL: begin
              busyQ[i] <= 1'b0;
              valQ[i]  <= srcData;
              dblQ[i]  <= issueDouble;
            end
            default: ;
          endcase
        end else if (cdbHit[i]) begin
          busyQ[i] <= 1'b0;
          valQ[i]  <= cdbData;
        end
      end
    end
  end

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_chk
    // R2 / R6: a retag leaves the register busy under the issued tag
    a_r2_retag: assert property (@(posedge clk) disable iff (!rst_n)
      (wrHit[g] && strobe.mode == WR_RETAG) |=> (busyQ[g] && tagQ[g] == $past(issueTag)));

    // R4: matching broadcast lands and frees the register
    a_r4_match_latch: assert property (@(posedge clk) disable iff (!rst_n)
      (busyQ[g] && cdbValid && cdbTag == tagQ[g] && !wrHit[g])
        |=> (!busyQ[g] && valQ[g] == $past(cdbData)));

    // R5: a non-matching broadcast leaves a busy register alone
    a_r5_no_match_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (busyQ[g] && !(cdbValid && cdbTag == tagQ[g]) && !wrHit[g])
        |=> (busyQ[g] && $stable(tagQ[g]) && $stable(valQ[g])));

    // R7: a move from a busy source inherits the source tag
    a_r7_copy_tag: assert property (@(posedge clk) disable iff (!rst_n)
      (wrHit[g] && strobe.mode == WR_COPYTAG) |=> (busyQ[g] && tagQ[g] == $past(srcTag)));

    // R10: a same-cycle retag beats the matching broadcast
    a_r10_issue_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (wrHit[g] && strobe.mode == WR_RETAG && cdbHit[g]) |=> busyQ[g]);
  end

endmodule

// File: rtl/reg_tag_tracker.sv
module reg_tag_tracker
  import rtt_pkg::*;
#(
  parameter int NUM_REGS = 4,
  parameter int TAG_W    = 4,
  parameter int DATA_W   = 64,
  localparam int IDX_W   = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issueValid,
  input  logic [1:0]        issueOp,
  input  logic [IDX_W-1:0]  issueDst,
  input  logic [IDX_W-1:0]  issueSrc,
  input  logic [TAG_W-1:0]  issueTag,
  input  logic              issueDouble,
  output logic              issueStall,
  output logic              sinkReady,
  output logic [TAG_W-1:0]  sinkTag,
  output logic [DATA_W-1:0] sinkData,
  output logic              srcReady,
  output logic [TAG_W-1:0]  srcTag,
  output logic [DATA_W-1:0] srcData,
  input  logic              cdbValid,
  input  logic [TAG_W-1:0]  cdbTag,
  input  logic [DATA_W-1:0] cdbData
);

  ctrlStrobe_t strobe;
  dpStatus_t   status;

  rtt_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .issueValid  (issueValid),
    .issueOp     (issueOp),
    .issueDouble (issueDouble),
    .status      (status),
    .issueStall  (issueStall),
    .strobe      (strobe)
  );

  rtt_data #(
    .NUM_REGS(NUM_REGS), .TAG_W(TAG_W), .DATA_W(DATA_W), .IDX_W(IDX_W)
  ) u_data (
    .clk         (clk),
    .rst_n       (rst_n),
    .strobe      (strobe),
    .issueDst    (issueDst),
    .issueSrc    (issueSrc),
    .issueTag    (issueTag),
    .issueDouble (issueDouble),
    .cdbValid    (cdbValid),
    .cdbTag      (cdbTag),
    .cdbData     (cdbData),
    .status      (status),
    .sinkReady   (sinkReady),
    .sinkTag     (sinkTag),
    .sinkData    (sinkData),
    .srcReady    (srcReady),
    .srcTag      (srcTag),
    .srcData     (srcData)
  );

endmodule

// File: tb/tb_reg_tag_tracker.sv
module tb_reg_tag_tracker;

  localparam logic [1:0] ARITH = 2'd0;
  localparam logic [1:0] LOAD  = 2'd1;
  localparam logic [1:0] MOVE  = 2'd2;
  localparam logic [1:0] STORE = 2'd3;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        issueValid;
  logic [1:0]  issueOp;
  logic [1:0]  issueDst;
  logic [1:0]  issueSrc;
  logic [3:0]  issueTag;
  logic        issueDouble;
  logic        issueStall;
  logic        sinkReady;
  logic [3:0]  sinkTag;
  logic [63:0] sinkData;
  logic        srcReady;
  logic [3:0]  srcTag;
  logic [63:0] srcData;
  logic        cdbValid;
  logic [3:0]  cdbTag;
  logic [63:0] cdbData;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic        sStall, sSinkR, sSrcR;
  logic [3:0]  sSinkT, sSrcT;
  logic [63:0] sSinkD, sSrcD;

  always #5 clk = ~clk;

  reg_tag_tracker dut (
    .clk(clk), .rst_n(rst_n),
    .issueValid(issueValid), .issueOp(issueOp), .issueDst(issueDst),
    .issueSrc(issueSrc), .issueTag(issueTag), .issueDouble(issueDouble),
    .issueStall(issueStall),
    .sinkReady(sinkReady), .sinkTag(sinkTag), .sinkData(sinkData),
    .srcReady(srcReady), .srcTag(srcTag), .srcData(srcData),
    .cdbValid(cdbValid), .cdbTag(cdbTag), .cdbData(cdbData)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // one cycle: drive at negedge, sample 1 ns later, commit on posedge
  task automatic step(input bit v, input logic [1:0] op, input int dst, input int src,
                      input int tag, input bit dbl, input bit cv, input int ct,
                      input logic [63:0] cd);
    issueValid  = v;
    issueOp     = op;
    issueDst    = 2'(dst);
    issueSrc    = 2'(src);
    issueTag    = 4'(tag);
    issueDouble = dbl;
    cdbValid    = cv;
    cdbTag      = 4'(ct);
    cdbData     = cd;
    #1;
    sStall = issueStall;
    sSinkR = sinkReady; sSinkT = sinkTag; sSinkD = sinkData;
    sSrcR  = srcReady;  sSrcT  = srcTag;  sSrcD  = srcData;
    @(posedge clk);
    @(negedge clk);
    issueValid = 1'b0;
    cdbValid   = 1'b0;
  endtask

  task automatic issue(input logic [1:0] op, input int dst, input int src,
                       input int tag, input bit dbl);
    step(1'b1, op, dst, src, tag, dbl, 1'b0, 0, 64'h0);
  endtask

  task automatic bcast(input int tag, input logic [63:0] d);
    step(1'b0, ARITH, 0, 0, 0, 1'b0, 1'b1, tag, d);
  endtask

  // store read of one register (R9 path)
  task automatic peek(input int r);
    step(1'b1, STORE, r, 0, 0, 1'b0, 1'b0, 0, 64'h0);
  endtask

  task automatic t_reset;
    for (int r = 0; r < 4; r++) begin
      peek(r);
      check("R1 ready after reset", 64'(sSinkR), 64'd1);
      check("R1 value after reset", sSinkD, 64'h0);
      check("R1 no stall", 64'(sStall), 64'd0);
    end
  endtask

  task automatic t_chain;
    issue(ARITH, 0, 2, 10, 1'b1);
    check("R2 idle source ready", 64'(sSrcR), 64'd1);
    check("R2 idle source value", sSrcD, 64'h0);
    peek(0);
    check("R2 dst busy", 64'(sSinkR), 64'd0);
    check("R2 dst tag", 64'(sSinkT), 64'd10);
    issue(ARITH, 0, 0, 11, 1'b1);
    check("R3 busy operand no stall", 64'(sStall), 64'd0);
    check("R3 busy sink not ready", 64'(sSinkR), 64'd0);
    check("R3 old tag presented", 64'(sSinkT), 64'd10);
    bcast(10, 64'hAAAA_0000_0000_0001);
    peek(0);
    check("R5 stale broadcast ignored busy", 64'(sSinkR), 64'd0);
    check("R5 stale broadcast ignored tag", 64'(sSinkT), 64'd11);
    bcast(11, 64'hBBBB_0000_0000_0002);
    peek(0);
    check("R4 match latched ready", 64'(sSinkR), 64'd1);
    check("R4 match latched value", sSinkD, 64'hBBBB_0000_0000_0002);
    // dependent producer then a load: only the load's value remains
    issue(ARITH, 0, 1, 10, 1'b1);
    issue(LOAD, 0, 0, 3, 1'b1);
    peek(0);
    check("R6 load retags busy reg", 64'(sSinkT), 64'd3);
    bcast(10, 64'hCCCC_0000_0000_0001);
    peek(0);
    check("R6 superseded producer ignored", 64'(sSinkR), 64'd0);
    bcast(3, 64'hCCCC_0000_0000_0002);
    peek(0);
    check("R6 last producer value", sSinkD, 64'hCCCC_0000_0000_0002);
  endtask

  task automatic t_move;
    issue(ARITH, 1, 1, 12, 1'b1);
    issue(MOVE, 3, 1, 0, 1'b1);
    peek(3);
    check("R7 move copies tag busy", 64'(sSinkR), 64'd0);
    check("R7 move copies tag value", 64'(sSinkT), 64'd12);
    bcast(12, 64'hDDDD_0000_0000_0001);
    peek(1);
    check("R4 R7 source latched", sSinkD, 64'hDDDD_0000_0000_0001);
    peek(3);
    check("R4 R7 copy latched same broadcast", sSinkD, 64'hDDDD_0000_0000_0001);
    issue(MOVE, 2, 3, 0, 1'b1);
    peek(2);
    check("R7 move from ready source idle", 64'(sSinkR), 64'd1);
    check("R7 move from ready source value", sSinkD, 64'hDDDD_0000_0000_0001);
  endtask

  task automatic t_prec;
    issue(ARITH, 1, 1, 8, 1'b1);
    issue(ARITH, 1, 1, 9, 1'b0);
    check("R8 precision clash stalls", 64'(sStall), 64'd1);
    peek(1);
    check("R8 stalled issue changed nothing", 64'(sSinkT), 64'd8);
    bcast(8, 64'hEEEE_0000_0000_0001);
    issue(ARITH, 1, 1, 9, 1'b0);
    check("R8 proceeds once idle", 64'(sStall), 64'd0);
    peek(1);
    check("R8 retag after stall", 64'(sSinkT), 64'd9);
    bcast(9, 64'hEEEE_0000_0000_0002);
  endtask

  task automatic t_store;
    step(1'b1, STORE, 2, 1, 5, 1'b0, 1'b0, 0, 64'h0);
    check("R9 store reads value", sSinkD, 64'hDDDD_0000_0000_0001);
    peek(2);
    check("R9 store leaves reg idle", 64'(sSinkR), 64'd1);
    check("R9 store leaves value", sSinkD, 64'hDDDD_0000_0000_0001);
  endtask

  task automatic t_same_cycle;
    issue(ARITH, 2, 0, 10, 1'b1);
    step(1'b1, ARITH, 2, 2, 11, 1'b1, 1'b1, 10, 64'hF0F0_0000_0000_0001);
    check("R10 sink bypass ready", 64'(sSinkR), 64'd1);
    check("R10 sink bypass data", sSinkD, 64'hF0F0_0000_0000_0001);
    check("R10 source bypass data", sSrcD, 64'hF0F0_0000_0000_0001);
    peek(2);
    check("R10 new tag wins busy", 64'(sSinkR), 64'd0);
    check("R10 new tag wins tag", 64'(sSinkT), 64'd11);
    bcast(11, 64'hF0F0_0000_0000_0002);
    peek(2);
    check("R10 newer producer lands", sSinkD, 64'hF0F0_0000_0000_0002);
  endtask

  initial begin
    issueValid = 1'b0; issueOp = 2'd0; issueDst = 2'd0; issueSrc = 2'd0;
    issueTag = 4'd0; issueDouble = 1'b0;
    cdbValid = 1'b0; cdbTag = 4'd0; cdbData = 64'h0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_chain();
    t_move();
    t_prec();
    t_store();
    t_same_cycle();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule